// File: doc/BRIEF.md
# Strobed Handshake Data Port

This block is one 8-bit data port with a handshake toward a peripheral. A separate configuration block selects one of three modes: plain latched I/O, strobed I/O in one direction, or strobed I/O in both directions over the same pins. The CPU side has single-cycle read and write pulses with data buses. The peripheral side has an input strobe pulse that captures the pad byte and an acknowledge pulse that fetches the output byte. The port keeps an input-buffer-full flag, an active-low output-buffer-full flag, one interrupt request and two interrupt-enable bits.

The data moves on single-cycle pulses, not on a valid/ready pair. There is no back-pressure. The flags are the flow control: a producer must wait for the matching flag before it sends the next byte, because a strobe over a full input latch or a write over a full output latch overwrites it. The pad drivers are outside the block, which gives out a drive enable and the byte to drive.

In the two-way mode a single interrupt line serves both directions. A CPU access therefore clears it only when the other direction has nothing pending.

Top module: `hs_pport`

## Requirements
- R1: A synchronous reset (`rst` high) clears both data latches, `ibf`, `intr` and `ien_q`, and sets `obf_n` to 1.
- R2: A `per_stb` pulse is accepted only in single-direction input mode (`cfg_mode`=1 with `cfg_dir_in`=1) or in two-way mode (`cfg_mode`=2). It latches `pad_in` into the input latch and sets `ibf`. It sets `intr` when `ien_q[0]` is 1.
- R3: A `cpu_rd` pulse in single-direction input mode or two-way mode clears `ibf`. It clears `intr` in single-direction mode. In two-way mode it clears `intr` only if `obf_n` was 1 before the pulse.
- R4: A `cpu_wr` pulse in single-direction output mode or two-way mode loads the output latch and clears `obf_n`. It clears `intr` in single-direction mode. In two-way mode it clears `intr` only if `ibf` was 0 before the pulse.
- R5: A `per_ack` pulse in single-direction output mode or two-way mode sets `obf_n`. It sets `intr` when `ien_q[1]` is 1.
- R6: `per_oe` is 1 in the output direction of plain and single-direction modes. In two-way mode it is 1 only during a `per_ack` cycle. `per_dout` is the output latch while `per_oe` is 1, and 8'hFF otherwise.
- R7: `cpu_rdata` returns the input latch in single-direction input mode and in two-way mode. It returns live `pad_in` in plain input mode and the output latch in the output direction. `cfg_mode`=3 behaves as plain mode.
- R8: When a CPU pulse and a peripheral pulse fall in the same cycle, the peripheral effect is applied last. For example, a read together with a strobe leaves `ibf` at 1.
- R9: A `cfg_change` pulse clears the output latch, `ibf` and `intr` and sets `obf_n`, and ignores every other pulse in that cycle. `ien_q` and the input latch keep their values.
- R10: Pulses outside their modes have no effect. A strobe or acknowledge in plain mode, a strobe in single-direction output mode, an acknowledge in single-direction input mode, and a write or read that does not match the direction leave the latches and the flags unchanged.
- R11: An `ien_we` pulse loads `ien_wdata` into `ien_q`. Bit 0 is the input-side enable and bit 1 is the output-side enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 0 plain, 1 single-direction strobed, 2 two-way strobed, 3 plain |
| cfg_dir_in | input | 1 | 1 = input direction (plain and single-direction modes) |
| cfg_change | input | 1 | Pulse sent when the configuration changes |
| ien_we | input | 1 | Interrupt-enable load pulse |
| ien_wdata | input | 2 | New interrupt enables |
| ien_q | output | 2 | Current interrupt enables |
| cpu_wr | input | 1 | CPU write pulse |
| cpu_rd | input | 1 | CPU read pulse |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| pad_in | input | 8 | Live pad value |
| per_stb | input | 1 | Peripheral input strobe pulse |
| per_ack | input | 1 | Peripheral acknowledge pulse |
| per_oe | output | 1 | Pad drive enable |
| per_dout | output | 8 | Byte presented to the pads |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
Each mode is driven in turn with the same kinds of pulses, both in and out of its direction. This separates accepted events from ignored ones, and shows whether a strobed read returns the latch or the live pads. The two-way mode gets interleaved write, strobe, read and acknowledge sequences, which leave the other direction's flag both pending and idle, so the conditional clearing of the shared interrupt is told apart from plain clearing. Same-cycle CPU and peripheral pulses show the ordering rule, and a configuration pulse sent over pending flags shows the clearing.

// File: rtl/hs_pport_pkg.sv
package hs_pport_pkg;
  typedef enum logic [1:0] {
    PM_PLAIN  = 2'd0,
    PM_SINGLE = 2'd1,
    PM_BIDIR  = 2'd2,
    PM_ALT    = 2'd3
  } pmode_e;

  localparam int unsigned IEN_W   = 2;
  localparam int unsigned IEN_IN  = 0;
  localparam int unsigned IEN_OUT = 1;
endpackage

// File: rtl/hs_pport_decode.sv
module hs_pport_decode
  import hs_pport_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       dir_in_i,
  output logic       single_o,
  output logic       bidir_o,
  output logic       acc_in_o,
  output logic       acc_out_o,
  output logic       wr_ok_o,
  output logic       static_drv_o
);
  pmode_e mode;
  assign mode = pmode_e'(mode_i);

  always_comb begin
    single_o     = (mode == PM_SINGLE);
    bidir_o      = (mode == PM_BIDIR);
    acc_in_o     = (single_o && dir_in_i) || bidir_o;
    acc_out_o    = (single_o && !dir_in_i) || bidir_o;
    wr_ok_o      = bidir_o || !dir_in_i;
    static_drv_o = !bidir_o && !dir_in_i;
  end
endmodule

// File: rtl/hs_pport_flags.sv
module hs_pport_flags
  import hs_pport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chg_i,
  input  logic             single_i,
  input  logic             bidir_i,
  input  logic             acc_in_i,
  input  logic             acc_out_i,
  input  logic             cpu_wr_i,
  input  logic             cpu_rd_i,
  input  logic             per_stb_i,
  input  logic             per_ack_i,
  input  logic             ien_we_i,
  input  logic [IEN_W-1:0] ien_wdata_i,
  output logic [IEN_W-1:0] ien_o,
  output logic             ibf_o,
  output logic             obf_n_o,
  output logic             intr_o
);
  logic ibf_d, obf_n_d, intr_d;

  always_comb begin
    ibf_d   = ibf_o;
    obf_n_d = obf_n_o;
    intr_d  = intr_o;
    if (chg_i) begin
      ibf_d   = 1'b0;
      obf_n_d = 1'b1;
      intr_d  = 1'b0;
    end else begin
      // CPU side first; gating uses the flags held before this cycle
      if (cpu_wr_i && acc_out_i) begin
        obf_n_d = 1'b0;
        if (single_i || !ibf_o) intr_d = 1'b0;
      end
      if (cpu_rd_i && acc_in_i) begin
        ibf_d = 1'b0;
        if (single_i || obf_n_o) intr_d = 1'b0;
      end
      // peripheral side last
      if (per_stb_i && acc_in_i) begin
        ibf_d = 1'b1;
        if (ien_o[IEN_IN]) intr_d = 1'b1;
      end
      if (per_ack_i && acc_out_i) begin
        obf_n_d = 1'b1;
        if (ien_o[IEN_OUT]) intr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf_o   <= 1'b0;
      obf_n_o <= 1'b1;
      intr_o  <= 1'b0;
      ien_o   <= '0;
    end else begin
      ibf_o   <= ibf_d;
      obf_n_o <= obf_n_d;
      intr_o  <= intr_d;
      if (ien_we_i) ien_o <= ien_wdata_i;
    end
  end

  assert_stb_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (per_stb_i && acc_in_i && !chg_i) |=> ibf_o);
  assert_rd_drains_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_i && acc_in_i && !per_stb_i && !chg_i) |=> !ibf_o);
  assert_bidir_rd_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (bidir_i && cpu_rd_i && !cpu_wr_i && !per_stb_i && !per_ack_i && !obf_n_o && intr_o && !chg_i)
      |=> intr_o);
  assert_wr_fills_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_i && acc_out_i && !per_ack_i && !chg_i) |=> !obf_n_o);
  assert_ack_empties_R5: assert property (@(posedge clk) disable iff (rst)
    (per_ack_i && acc_out_i && !chg_i) |=> obf_n_o);
  assert_change_clears_R9: assert property (@(posedge clk) disable iff (rst)
    chg_i |=> (!ibf_o && obf_n_o && !intr_o));
  assert_plain_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!single_i && !bidir_i && !chg_i) |=> ($stable(intr_o) && $stable(ibf_o) && $stable(obf_n_o)));
endmodule

// File: rtl/hs_pport_data.sv
module hs_pport_data #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chg_i,
  input  logic          bidir_i,
  input  logic          acc_in_i,
  input  logic          wr_ok_i,
  input  logic          static_drv_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          per_stb_i,
  input  logic          per_ack_i,
  input  logic [DW-1:0] pad_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          per_oe_o,
  output logic [DW-1:0] per_dout_o
);
  localparam logic [DW-1:0] IDLE_BYTE = '1;

  logic [DW-1:0] out_q, in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      in_q  <= '0;
    end else if (chg_i) begin
      out_q <= '0;
    end else begin
      if (cpu_wr_i && wr_ok_i) out_q <= cpu_wdata_i;
      if (per_stb_i && acc_in_i) in_q <= pad_i;
    end
  end

  always_comb begin
    if (acc_in_i)      cpu_rdata_o = in_q;
    else if (!wr_ok_i) cpu_rdata_o = pad_i;
    else               cpu_rdata_o = out_q;
    per_oe_o   = static_drv_i || (bidir_i && per_ack_i);
    per_dout_o = per_oe_o ? out_q : IDLE_BYTE;
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (per_stb_i && acc_in_i && !chg_i) |=> (in_q == $past(pad_i)));
  assert_bidir_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (bidir_i && !per_ack_i) |-> (!per_oe_o && per_dout_o == IDLE_BYTE));
  assert_change_out_R9: assert property (@(posedge clk) disable iff (rst)
    chg_i |=> (out_q == '0));
endmodule

// File: rtl/hs_pport.sv
module hs_pport
  import hs_pport_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_dir_in,
  input  logic             cfg_change,
  input  logic             ien_we,
  input  logic [IEN_W-1:0] ien_wdata,
  output logic [IEN_W-1:0] ien_q,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic [DW-1:0]    pad_in,
  input  logic             per_stb,
  input  logic             per_ack,
  output logic             per_oe,
  output logic [DW-1:0]    per_dout,
  output logic             ibf,
  output logic             obf_n,
  output logic             intr
);
  logic single, bidir, acc_in, acc_out, wr_ok, static_drv;

  hs_pport_decode u_dec (
    .mode_i      (cfg_mode),
    .dir_in_i    (cfg_dir_in),
    .single_o    (single),
    .bidir_o     (bidir),
    .acc_in_o    (acc_in),
    .acc_out_o   (acc_out),
    .wr_ok_o     (wr_ok),
    .static_drv_o(static_drv)
  );

  hs_pport_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .chg_i      (cfg_change),
    .single_i   (single),
    .bidir_i    (bidir),
    .acc_in_i   (acc_in),
    .acc_out_i  (acc_out),
    .cpu_wr_i   (cpu_wr),
    .cpu_rd_i   (cpu_rd),
    .per_stb_i  (per_stb),
    .per_ack_i  (per_ack),
    .ien_we_i   (ien_we),
    .ien_wdata_i(ien_wdata),
    .ien_o      (ien_q),
    .ibf_o      (ibf),
    .obf_n_o    (obf_n),
    .intr_o     (intr)
  );

  hs_pport_data #(.DW(DW)) u_data (
    .clk         (clk),
    .rst         (rst),
    .chg_i       (cfg_change),
    .bidir_i     (bidir),
    .acc_in_i    (acc_in),
    .wr_ok_i     (wr_ok),
    .static_drv_i(static_drv),
    .cpu_wr_i    (cpu_wr),
    .cpu_wdata_i (cpu_wdata),
    .per_stb_i   (per_stb),
    .per_ack_i   (per_ack),
    .pad_i       (pad_in),
    .cpu_rdata_o (cpu_rdata),
    .per_oe_o    (per_oe),
    .per_dout_o  (per_dout)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!ibf && obf_n && !intr && ien_q == '0));
  assert_ien_load_R11: assert property (@(posedge clk) disable iff (rst)
    ien_we |=> (ien_q == $past(ien_wdata)));
endmodule

// File: tb/hs_pport_tb_top.sv
`timescale 1ns/1ps
module hs_pport_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_dir_in = 1'b0;
  logic       cfg_change = 1'b0;
  logic       ien_we = 1'b0;
  logic [1:0] ien_wdata = 2'd0;
  logic [1:0] ien_q;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00, cpu_rdata;
  logic [7:0] pad_in = 8'h00;
  logic       per_stb = 1'b0, per_ack = 1'b0;
  logic       per_oe;
  logic [7:0] per_dout;
  logic       ibf, obf_n, intr;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_in = 0, m_out = 0, m_ibf = 0, m_obfn = 1, m_intr = 0, m_ien = 0;

  always #2.5 clk = ~clk;

  hs_pport dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dir_in(cfg_dir_in),
    .cfg_change(cfg_change), .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_q(ien_q),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pad_in(pad_in), .per_stb(per_stb), .per_ack(per_ack), .per_oe(per_oe),
    .per_dout(per_dout), .ibf(ibf), .obf_n(obf_n), .intr(intr)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int mode = int'(cfg_mode);
    int dir = int'(cfg_dir_in);
    int e_rd, e_oe, e_do;
    if (mode == 2 || (mode == 1 && dir == 1)) e_rd = m_in;
    else if (dir == 1) e_rd = int'(pad_in);
    else e_rd = m_out;
    e_oe = ((mode != 2 && dir == 0) || (mode == 2 && per_ack)) ? 1 : 0;
    e_do = e_oe ? m_out : 8'hFF;
    chk(tag, "cpu_rdata", int'(cpu_rdata), e_rd);
    chk(tag, "per_oe", int'(per_oe), e_oe);
    chk(tag, "per_dout", int'(per_dout), e_do);
    chk(tag, "ibf", int'(ibf), m_ibf);
    chk(tag, "obf_n", int'(obf_n), m_obfn);
    chk(tag, "intr", int'(intr), m_intr);
    chk(tag, "ien_q", int'(ien_q), m_ien);
  endtask

  task automatic model_edge();
    int mode = int'(cfg_mode);
    bit single = (mode == 1);
    bit bid = (mode == 2);
    bit ain = (single && cfg_dir_in) || bid;
    bit aout = (single && !cfg_dir_in) || bid;
    int p_ibf = m_ibf, p_obfn = m_obfn;
    if (rst) begin
      m_in = 0; m_out = 0; m_ibf = 0; m_obfn = 1; m_intr = 0; m_ien = 0;
      return;
    end
    if (ien_we) m_ien = int'(ien_wdata);
    if (cfg_change) begin
      m_out = 0; m_ibf = 0; m_obfn = 1; m_intr = 0;
      return;
    end
    if (cpu_wr && (bid || !cfg_dir_in)) m_out = int'(cpu_wdata);
    if (cpu_wr && aout) begin
      m_obfn = 0;
      if (single || p_ibf == 0) m_intr = 0;
    end
    if (cpu_rd && ain) begin
      m_ibf = 0;
      if (single || p_obfn == 1) m_intr = 0;
    end
    if (per_stb && ain) begin
      m_in = int'(pad_in); m_ibf = 1;
      if (m_ien[0]) m_intr = 1;
    end
    if (per_ack && aout) begin
      m_obfn = 1;
      if (m_ien[1]) m_intr = 1;
    end
  endtask

  // one cycle: inputs already set at a negedge; compare, advance, drop pulses
  task automatic step(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_change = 0; ien_we = 0; cpu_wr = 0; cpu_rd = 0; per_stb = 0; per_ack = 0;
  endtask

  task automatic set_mode(int mode, bit dir);
    cfg_mode = 2'(mode); cfg_dir_in = dir; cfg_change = 1;
  endtask

  task automatic set_ien(int v);
    ien_we = 1; ien_wdata = 2'(v);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    step("R1");
    // plain output
    cpu_wr = 1; cpu_wdata = 8'hA5; step("R7");
    step("R6");
    per_stb = 1; pad_in = 8'h5A; step("R10");
    per_ack = 1; step("R10");
    // plain input
    set_mode(0, 1); step("R9");
    pad_in = 8'h3C; step("R7");
    cpu_wr = 1; cpu_wdata = 8'h11; step("R10");
    per_ack = 1; step("R6");
    cfg_dir_in = 0; step("R10");
    // single-direction input
    set_mode(1, 1); step("R9");
    step("R10");
    set_ien(1); step("R11");
    pad_in = 8'hC3; per_stb = 1; step("R2");
    pad_in = 8'h00; step("R7");
    cpu_rd = 1; step("R3");
    step("R3");
    per_ack = 1; step("R10");
    cpu_wr = 1; cpu_wdata = 8'h77; step("R10");
    set_ien(0); step("R11");
    pad_in = 8'h81; per_stb = 1; step("R2");
    cpu_rd = 1; step("R3");
    set_ien(1); step("R11");
    cpu_rd = 1; per_stb = 1; pad_in = 8'h42; step("R8");
    step("R8");
    // single-direction output
    set_mode(1, 0); step("R9");
    set_ien(2); step("R11");
    cpu_wr = 1; cpu_wdata = 8'h9E; step("R4");
    step("R6");
    per_ack = 1; step("R5");
    step("R5");
    cpu_wr = 1; cpu_wdata = 8'hE9; step("R4");
    cpu_wr = 1; per_ack = 1; cpu_wdata = 8'h12; step("R8");
    step("R8");
    per_stb = 1; pad_in = 8'hEE; step("R10");
    cpu_rd = 1; step("R10");
    // two-way
    set_mode(2, 0); step("R9");
    set_ien(3); step("R11");
    cpu_wr = 1; cpu_wdata = 8'hB4; step("R4");
    step("R6");
    per_stb = 1; pad_in = 8'h6D; step("R2");
    cpu_rd = 1; step("R3");
    step("R3");
    per_ack = 1; step("R6");
    step("R5");
    per_stb = 1; pad_in = 8'h19; step("R2");
    cpu_wr = 1; cpu_wdata = 8'h2C; step("R4");
    cpu_rd = 1; step("R3");
    per_ack = 1; step("R5");
    cpu_wr = 1; cpu_wdata = 8'hD7; step("R4");
    step("R4");
    per_stb = 1; pad_in = 8'h55; step("R2");
    cpu_wr = 1; per_ack = 1; cpu_wdata = 8'h3A; step("R8");
    set_mode(2, 1); per_stb = 1; cpu_wr = 1; step("R9");
    step("R9");
    // reserved encoding acts as plain
    set_mode(3, 1); pad_in = 8'hF0; step("R7");
    per_stb = 1; step("R10");
    cfg_dir_in = 0; step("R7");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule